// File: doc/BRIEF.md
# Two-Beat Burst Common-Data SRAM Core

This block models a pipelined synchronous SRAM whose every access moves exactly two data words. A command is taken on a rising clock edge when the active-low select is low. A separate control bit picks read or write, and one shared address bus carries the word address. The double-rate data path is split into two beat lanes per clock cycle, so every flop is clocked on one edge only. On the write side, `wr_beat0`/`wr_beat1` carry the first and second word in time order. On the read side, `rd_beat0`/`rd_beat1` carry them the same way, and `rd_drive` marks the cycles in which read words are on the bus. `rd_drive` serves as both the output enable and the beat strobe.

The lowest address bit picks the word that comes first, and the second word is its partner within the aligned pair. Write data arrives one cycle after the write command and is held in a pending-write stage for one more cycle before it reaches the array. Each 9-bit byte lane of each word has its own active-low mask. A read that lands while a write to the same pair is still pending returns the pending bytes, merged with the array contents byte by byte.

Top module: `burst2_sram`

## Requirements
- R1: With `sel_n` high at a clock edge, no command is taken: the array is not written and `rd_drive` stays low two edges later, whatever `is_read`, `word_addr` and the data inputs carry.
- R2: With `sel_n` low at an edge, `is_read` high starts a read and `is_read` low starts a write.
- R3: Read data appears after the second rising edge counting the command edge. For exactly one cycle `rd_drive` is high, `rd_beat0` holds the first word and `rd_beat1` holds the second.
- R4: Burst order depends on address bit 0. With bit 0 at 0, word {pair,0} comes first and {pair,1} second. With bit 0 at 1, word {pair,1} comes first and {pair,0} second.
- R5: Reads taken on consecutive edges keep `rd_drive` high on consecutive cycles, with a new burst on every cycle.
- R6: When `sel_n` goes high after a read, that burst is still delivered, and `rd_drive` drops in the cycle after it.
- R7: Write data is sampled from `wr_beat0`/`wr_beat1` at the first edge after the write command edge. `wr_beat0` goes to the starting word and `wr_beat1` goes to its partner.
- R8: Masks are active low, one bit per 9-bit lane: bit k of `wmask_n0`/`wmask_n1` guards bits [9k+8:9k] of the first/second write word. A lane whose mask bit is 1 keeps its old contents.
- R9: A read taken on the same edge that samples write data for the same pair returns the new bytes where they were enabled, and the older array contents in the other lanes.
- R10: A synchronous reset clears `rd_drive` and both read lanes. Whenever `rd_drive` is low, both read lanes are zero.
- R11: A write command never raises `rd_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low command select |
| is_read | input | 1 | 1 = read, 0 = write when selected |
| word_addr | input | ADDR_W | Word address; bit 0 picks the starting word of the pair |
| wr_beat0 | input | DATA_W | First write word, in the cycle after a write command |
| wr_beat1 | input | DATA_W | Second write word, same cycle |
| wmask_n0 | input | DATA_W/9 | Active-low lane masks for the first write word |
| wmask_n1 | input | DATA_W/9 | Active-low lane masks for the second write word |
| rd_beat0 | output | DATA_W | First read word |
| rd_beat1 | output | DATA_W | Second read word |
| rd_drive | output | 1 | Read words valid; bus output enable |

## Verification
The bench builds the core with DATA_W = 36 and ADDR_W = 4. Four byte lanes allow masks with enabled and disabled lanes interleaved, so a merge that swaps or drops a lane cannot go unnoticed. Sixteen words are few enough that every pair is written, and then read back in both burst orders against a full reference copy. The coherent-read case is aimed at a pair whose old contents differ from the new write in every lane. That way each merged byte shows which source it came from.

// File: rtl/burst2_pkg.sv
package burst2_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/burst2_cmd.sv
// Command decode and address register: one stage, sampled at the command edge.
module burst2_cmd
  import burst2_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int PAIR_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] word_addr,
  output op_e               op_q,
  output logic [PAIR_W-1:0] pair_q,
  output logic              first_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_NONE;
      pair_q  <= '0;
      first_q <= 1'b0;
    end else begin
      if (sel_n)        op_q <= OP_NONE;
      else if (is_read) op_q <= OP_READ;
      else              op_q <= OP_WRITE;
      pair_q  <= word_addr[ADDR_W-1:1];
      first_q <= word_addr[0];
    end
  end

endmodule

// File: rtl/burst2_wstage.sv
// Late-write stage: captures both beats one edge after the command, steered to banks.
module burst2_wstage
  import burst2_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int PAIR_W = ADDR_W - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  op_e                          op_q,
  input  logic [PAIR_W-1:0]            pair_q,
  input  logic                         first_q,
  input  logic [DATA_W-1:0]            wr_beat0,
  input  logic [DATA_W-1:0]            wr_beat1,
  input  logic [NLANE-1:0]             wmask_n0,
  input  logic [NLANE-1:0]             wmask_n1,
  output logic                         pend_vld,
  output logic [PAIR_W-1:0]            pend_pair,
  output logic [1:0][DATA_W-1:0]       pend_data,
  output logic [1:0][NLANE-1:0]        pend_en
);

  logic second;
  assign second = ~first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld  <= 1'b0;
      pend_pair <= '0;
      pend_data <= '0;
      pend_en   <= '0;
    end else begin
      pend_vld <= (op_q == OP_WRITE);
      if (op_q == OP_WRITE) begin
        pend_pair         <= pair_q;
        pend_data[first_q] <= wr_beat0;
        pend_data[second]  <= wr_beat1;
        pend_en[first_q]   <= ~wmask_n0;
        pend_en[second]    <= ~wmask_n1;
      end
    end
  end

endmodule

// File: rtl/burst2_array.sv
// Storage: two banks split on address bit 0, each split into byte lanes.
module burst2_array #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int PAIR_W = ADDR_W - 1,
  localparam int DEPTH  = 1 << PAIR_W
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [PAIR_W-1:0]      wpair,
  input  logic [1:0][DATA_W-1:0] wdata,
  input  logic [1:0][NLANE-1:0]  wen,
  input  logic [PAIR_W-1:0]      rpair,
  output logic [1:0][DATA_W-1:0] rdata
);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we && wen[b][l])
          mem[wpair] <= wdata[b][l*LANE_W +: LANE_W];
      end

      assign rdata[b][l*LANE_W +: LANE_W] = mem[rpair];
    end
  end

endmodule

// File: rtl/burst2_rpipe.sv
// Read stage: merges pending-write bytes over array data and registers both beats.
module burst2_rpipe
  import burst2_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int PAIR_W = ADDR_W - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  op_e                    op_q,
  input  logic [PAIR_W-1:0]      pair_q,
  input  logic                   first_q,
  input  logic                   pend_vld,
  input  logic [PAIR_W-1:0]      pend_pair,
  input  logic [1:0][DATA_W-1:0] pend_data,
  input  logic [1:0][NLANE-1:0]  pend_en,
  input  logic [1:0][DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0]      rd_beat0,
  output logic [DATA_W-1:0]      rd_beat1,
  output logic                   rd_drive
);

  logic                   hit;
  logic [1:0][DATA_W-1:0] merged;
  logic                   second;

  assign hit    = pend_vld && (pend_pair == pair_q);
  assign second = ~first_q;

  always_comb begin
    merged = arr_rdata;
    for (int b = 0; b < 2; b++) begin
      for (int l = 0; l < NLANE; l++) begin
        if (hit && pend_en[b][l])
          merged[b][l*LANE_W +: LANE_W] = pend_data[b][l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_drive <= 1'b0;
      rd_beat0 <= '0;
      rd_beat1 <= '0;
    end else if (op_q == OP_READ) begin
      rd_drive <= 1'b1;
      rd_beat0 <= merged[first_q];
      rd_beat1 <= merged[second];
    end else begin
      rd_drive <= 1'b0;
      rd_beat0 <= '0;
      rd_beat1 <= '0;
    end
  end

endmodule

// File: rtl/burst2_sram.sv
// Top: two-beat burst SRAM core with late write and coherent reads.
module burst2_sram
  import burst2_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  localparam int NLANE  = DATA_W / LANE_W,
  localparam int PAIR_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DATA_W-1:0] wr_beat0,
  input  logic [DATA_W-1:0] wr_beat1,
  input  logic [NLANE-1:0]  wmask_n0,
  input  logic [NLANE-1:0]  wmask_n1,
  output logic [DATA_W-1:0] rd_beat0,
  output logic [DATA_W-1:0] rd_beat1,
  output logic              rd_drive
);

  op_e                    op_q;
  logic [PAIR_W-1:0]      pair_q;
  logic                   first_q;
  logic                   pend_vld;
  logic [PAIR_W-1:0]      pend_pair;
  logic [1:0][DATA_W-1:0] pend_data;
  logic [1:0][NLANE-1:0]  pend_en;
  logic [1:0][DATA_W-1:0] arr_rdata;

  burst2_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .sel_n(sel_n), .is_read(is_read),
    .word_addr(word_addr), .op_q(op_q), .pair_q(pair_q), .first_q(first_q)
  );

  burst2_wstage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_wst (
    .clk(clk), .rst(rst), .op_q(op_q), .pair_q(pair_q), .first_q(first_q),
    .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .wmask_n0(wmask_n0), .wmask_n1(wmask_n1),
    .pend_vld(pend_vld), .pend_pair(pend_pair),
    .pend_data(pend_data), .pend_en(pend_en)
  );

  burst2_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(pend_vld), .wpair(pend_pair), .wdata(pend_data),
    .wen(pend_en), .rpair(pair_q), .rdata(arr_rdata)
  );

  burst2_rpipe #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst(rst), .op_q(op_q), .pair_q(pair_q), .first_q(first_q),
    .pend_vld(pend_vld), .pend_pair(pend_pair), .pend_data(pend_data),
    .pend_en(pend_en), .arr_rdata(arr_rdata),
    .rd_beat0(rd_beat0), .rd_beat1(rd_beat1), .rd_drive(rd_drive)
  );

endmodule

// File: rtl/burst2_sram_chk.sv
// Port-level protocol checks, bound to the top module.
module burst2_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              is_read,
  input logic [DATA_W-1:0] rd_beat0,
  input logic [DATA_W-1:0] rd_beat1,
  input logic              rd_drive
);

  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_DRIVE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (rd_drive == $past(!sel_n && is_read, 2))); // R3

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(sel_n, 2)) |-> !rd_drive); // R1

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && $past(!sel_n && !is_read, 2)) |-> !rd_drive); // R11

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_drive |-> (rd_beat0 == '0 && rd_beat1 == '0)); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rd_drive); // R10

endmodule

bind burst2_sram burst2_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .is_read(is_read),
  .rd_beat0(rd_beat0), .rd_beat1(rd_beat1), .rd_drive(rd_drive)
);

// File: tb/sim_burst2_sram.sv
module sim_burst2_sram;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int NL = DW / LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1;
  logic          is_read = 1'b0;
  logic [AW-1:0] word_addr = '0;
  logic [DW-1:0] wr_beat0 = '0;
  logic [DW-1:0] wr_beat1 = '0;
  logic [NL-1:0] wmask_n0 = '1;
  logic [NL-1:0] wmask_n1 = '1;
  logic [DW-1:0] rd_beat0;
  logic [DW-1:0] rd_beat1;
  logic          rd_drive;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #10 clk = ~clk;

  burst2_sram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .is_read(is_read),
    .word_addr(word_addr), .wr_beat0(wr_beat0), .wr_beat1(wr_beat1),
    .wmask_n0(wmask_n0), .wmask_n1(wmask_n1),
    .rd_beat0(rd_beat0), .rd_beat1(rd_beat1), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return {9'(i * 11 + 1), 9'(i * 13 + 2), 9'(i * 17 + 3), 9'(i * 19 + 4)};
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    for (int l = 0; l < NL; l++) begin
      if (!m0[l]) ref_mem[a][l*LW +: LW] = d0[l*LW +: LW];
      if (!m1[l]) ref_mem[a ^ 1][l*LW +: LW] = d1[l*LW +: LW];
    end
  endtask

  // Write command, data on the next cycle; drive must stay low (R11, R7).
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                          input logic [NL-1:0] m0, input logic [NL-1:0] m1);
    @(negedge clk);
    sel_n = 1'b0; is_read = 1'b0; word_addr = a;
    @(negedge clk);
    sel_n = 1'b1; wr_beat0 = d0; wr_beat1 = d1; wmask_n0 = m0; wmask_n1 = m1;
    @(negedge clk);
    chk("R11 drive during write", DW'(rd_drive), '0);
    wr_beat0 = '1; wr_beat1 = '1; wmask_n0 = '0; wmask_n1 = '0;
    model_wr(a, d0, d1, m0, m1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    sel_n = 1'b0; is_read = 1'b1; word_addr = a;
    @(negedge clk);
    sel_n = 1'b1; is_read = 1'b0;
    @(negedge clk);
    chk({req, " drive"}, DW'(rd_drive), DW'(1));
    chk({req, " beat0"}, rd_beat0, ref_mem[a]);
    chk({req, " beat1"}, rd_beat1, ref_mem[a ^ 1]);
  endtask

  task automatic t_reset;
    chk("R10 reset drive", DW'(rd_drive), '0);
    chk("R10 reset beat0", rd_beat0, '0);
    chk("R10 reset beat1", rd_beat1, '0);
  endtask

  // Fill every pair, read back in both orders (R2, R3, R4, R7).
  task automatic t_fill;
    for (int p = 0; p < (1 << (AW - 1)); p++)
      do_write(AW'(p * 2), pat(2 * p), pat(2 * p + 1), '0, '0);
    for (int p = 0; p < (1 << (AW - 1)); p++) begin
      do_read(AW'(p * 2), "R3 R2 R7 order0");
      do_read(AW'(p * 2 + 1), "R4 order1");
    end
  endtask

  // Write starting at the odd word: beat0 must land on the odd word (R7, R4).
  task automatic t_write_odd;
    do_write(AW'(7), pat(40), pat(41), '0, '0);
    do_read(AW'(6), "R7 odd start read even");
    chk("R7 odd word holds beat0", ref_mem[7], pat(40));
  endtask

  // Partial lane masks (R8).
  task automatic t_masks;
    do_write(AW'(4), pat(50), pat(51), 4'b1010, 4'b0110);
    do_read(AW'(4), "R8 mask");
    do_write(AW'(5), pat(52), pat(53), 4'b1111, 4'b1110);
    do_read(AW'(4), "R8 mask all-off beat0");
  endtask

  // Back-to-back reads, then deselect (R5, R6).
  task automatic t_back_to_back;
    @(negedge clk);
    sel_n = 1'b0; is_read = 1'b1; word_addr = AW'(2);
    @(negedge clk);
    word_addr = AW'(9);
    @(negedge clk);
    sel_n = 1'b1; is_read = 1'b0;
    chk("R5 first burst drive", DW'(rd_drive), DW'(1));
    chk("R5 first burst beat0", rd_beat0, ref_mem[2]);
    chk("R5 first burst beat1", rd_beat1, ref_mem[3]);
    @(negedge clk);
    chk("R6 second burst drive", DW'(rd_drive), DW'(1));
    chk("R5 second burst beat0", rd_beat0, ref_mem[9]);
    chk("R5 second burst beat1", rd_beat1, ref_mem[8]);
    @(negedge clk);
    chk("R6 drive off after burst", DW'(rd_drive), '0);
    chk("R10 idle beat0 zero", rd_beat0, '0);
  endtask

  // sel_n high: neither a write nor a read may happen (R1).
  task automatic t_deselect;
    @(negedge clk);
    sel_n = 1'b1; is_read = 1'b0; word_addr = AW'(12);
    wr_beat0 = pat(60); wr_beat1 = pat(61); wmask_n0 = '0; wmask_n1 = '0;
    @(negedge clk);
    is_read = 1'b1;
    @(negedge clk);
    chk("R1 no drive deselected", DW'(rd_drive), '0);
    @(negedge clk);
    chk("R1 no drive deselected read", DW'(rd_drive), '0);
    chk("R1 beat1 zero", rd_beat1, '0);
    is_read = 1'b0;
    do_read(AW'(12), "R1 contents unchanged");
  endtask

  // Read on the edge that samples write data for the same pair (R9).
  task automatic t_coherent;
    @(negedge clk);
    sel_n = 1'b0; is_read = 1'b0; word_addr = AW'(11);
    @(negedge clk);
    wr_beat0 = pat(70); wr_beat1 = pat(71); wmask_n0 = 4'b0101; wmask_n1 = 4'b0011;
    is_read = 1'b1; word_addr = AW'(10);
    model_wr(AW'(11), pat(70), pat(71), 4'b0101, 4'b0011);
    @(negedge clk);
    sel_n = 1'b1; is_read = 1'b0;
    wr_beat0 = '1; wr_beat1 = '1; wmask_n0 = '0; wmask_n1 = '0;
    chk("R11 no drive for write", DW'(rd_drive), '0);
    @(negedge clk);
    chk("R9 coherent drive", DW'(rd_drive), DW'(1));
    chk("R9 coherent beat0", rd_beat0, ref_mem[10]);
    chk("R9 coherent beat1", rd_beat1, ref_mem[11]);
    do_read(AW'(11), "R9 committed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_fill;
    t_write_odd;
    t_masks;
    t_back_to_back;
    t_deselect;
    t_coherent;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule